// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a single-port synchronous memory. It can switch between reads and writes on consecutive clock cycles without any idle cycle. Address, operation, byte selects and chip enables are all captured on the rising clock edge. A read returns its word combinationally from the captured address during the cycle that follows, with no output register. A write takes its data one cycle after its address. The output is therefore never asked to drive while the bus carries write data, and a read can follow a write directly.

A clock enable freezes the whole block. Three chip enables allow several instances to share an address space. An output enable gates the read-valid flag asynchronously, and that flag stands in for the pad driver. A burst-continue input moves the low two address bits through a four-word group, in either linear or interleaved order, and reuses the operation that was last loaded. The default word is 36 bits, made of four 9-bit lanes. Setting the lane count to two gives an 18-bit word.

Top module: `zt_sram`

## Requirements
- R1: After reset and before any selected command, `rvalid` is 0 and `rdata` is all zeros.
- R2: A read sampled at edge N presents `mem[addr]` on `rdata`, with `rvalid`=1, in the cycle directly after edge N.
- R3: Lane i is bits [9*i+8 : 9*i] in the default configuration. A write changes lane i only when `byte_sel[i]` was 1 at its address edge. All other lanes keep their old contents.
- R4: For a write sampled at edge N, `wdata` is sampled and stored at the next enabled edge. A read of the same address sampled at that edge returns the new data. Reads and writes can alternate on every enabled cycle.
- R5: While `cke`=0, every input is ignored and all state holds. A read keeps presenting its data. A pending write waits and stores the `wdata` present at the next edge where `cke`=1.
- R6: During the data cycle of a write, `rvalid`=0 and `rdata`=0, whatever the value of `oe_n`.
- R7: `oe_n`=1 forces `rvalid` to 0 and `rdata` to 0 at once, without waiting for a clock edge. Lowering `oe_n` again restores the read output.
- R8: The block is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. A deselected cycle neither reads nor writes, and leaves `rvalid`=0.
- R9: With `burst_cont`=1 and `seq_mode`=1 (linear order), the k-th continuation after a load from start offset s uses low address bits (s+k) mod 4. The upper address bits and the loaded read/write type are kept.
- R10: With `burst_cont`=1 and `seq_mode`=0 (interleaved order), the k-th continuation uses low address bits s XOR k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke | input | 1 | Clock enable; 0 freezes the block |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| we | input | 1 | 1 = write, 0 = read, for a loaded command |
| burst_cont | input | 1 | 1 = advance the burst instead of loading `addr` |
| seq_mode | input | 1 | Burst order: 1 = linear, 0 = interleaved |
| addr | input | ADDR_W | Word address |
| byte_sel | input | LANES | Per-lane write select, active high |
| wdata | input | LANE_W*LANES | Write data, sampled one enabled cycle after its address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | LANE_W*LANES | Flow-through read data, zero when not valid |
| rvalid | output | 1 | Output-drive flag |

## Verification
Read results are due in the same cycle as the edge that sampled the read, because there is no output stage. The bench drives its inputs 2 time units after each rising edge and samples the outputs at that same point, before it drives the next command. A write's data is stored at the edge that follows its address. The bench therefore supplies the data with the next command and checks the stored value through a later read. Output-enable effects are checked 1 time unit after `oe_n` changes, with no clock edge in between. Stalls are checked by holding `cke` low over several edges and confirming that both the outputs and the later read-back are unchanged.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  localparam int OFF_W = 2;

  typedef enum logic {
    ORDER_INTERLEAVE = 1'b0,
    ORDER_LINEAR     = 1'b1
  } burst_order_e;

  function automatic logic [OFF_W-1:0] burst_offset(
    input logic [OFF_W-1:0] start,
    input logic [OFF_W-1:0] step,
    input burst_order_e     order
  );
    if (order == ORDER_LINEAR) return start + step;
    else                       return start ^ step;
  endfunction
endpackage

// File: rtl/zt_rst_sync.sv
module zt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/zt_sram_ctrl.sv
module zt_sram_ctrl
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              we,
  input  logic              burst_cont,
  input  logic              seq_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byte_sel,
  output logic              cmd_vld,
  output logic              cmd_wr,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LANES-1:0]  cmd_be
);
  logic              sel;
  logic [ADDR_W-1:0] base_q, base_n;
  logic [OFF_W-1:0]  cnt_q, cnt_n;
  logic              lastwr_q, lastwr_n;
  logic              vld_n, wr_n;
  logic [ADDR_W-1:0] addr_n;
  logic [OFF_W-1:0]  off;

  assign sel = !cs1_n && cs2 && !cs3_n;

  always_comb begin
    base_n   = base_q;
    cnt_n    = cnt_q;
    lastwr_n = lastwr_q;
    vld_n    = sel;
    wr_n     = 1'b0;
    addr_n   = cmd_addr;
    off      = '0;
    if (sel) begin
      if (!burst_cont) begin
        base_n   = addr;
        cnt_n    = '0;
        lastwr_n = we;
        wr_n     = we;
        addr_n   = addr;
      end else begin
        cnt_n  = cnt_q + 1'b1;
        off    = burst_offset(base_q[OFF_W-1:0], cnt_n, burst_order_e'(seq_mode));
        wr_n   = lastwr_q;
        addr_n = {base_q[ADDR_W-1:OFF_W], off};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_vld  <= 1'b0;
      cmd_wr   <= 1'b0;
      cmd_addr <= '0;
      cmd_be   <= '0;
      base_q   <= '0;
      cnt_q    <= '0;
      lastwr_q <= 1'b0;
    end else if (cke) begin
      cmd_vld  <= vld_n;
      cmd_wr   <= wr_n;
      cmd_addr <= addr_n;
      cmd_be   <= byte_sel;
      base_q   <= base_n;
      cnt_q    <= cnt_n;
      lastwr_q <= lastwr_n;
    end
  end

  // R5: a stalled edge changes no command or burst state
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ($stable(cmd_vld) && $stable(cmd_addr) && $stable(cmd_wr) && $stable(cnt_q)));

  // R8: a deselected enabled edge leaves no command
  a_r8_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !sel) |=> !cmd_vld);

  // R9: a continuation stays inside the group and keeps the operation type
  a_r9_burst_group: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && sel && burst_cont && cmd_vld) |=>
      (cmd_addr[ADDR_W-1:OFF_W] == $past(cmd_addr[ADDR_W-1:OFF_W])) && (cmd_wr == $past(cmd_wr)));
endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  parameter int ADDR_W = 6
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [LANES-1:0]        wr_be,
  input  logic [LANE_W*LANES-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [LANE_W*LANES-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && wr_be[g]) store[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
    end

    assign rd_data[g*LANE_W +: LANE_W] = store[rd_addr];
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  parameter int ADDR_W = 6,
  localparam int DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              we,
  input  logic              burst_cont,
  input  logic              seq_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byte_sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic              rst_int_n;
  logic              cmd_vld, cmd_wr;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LANES-1:0]  cmd_be;
  logic              commit;
  logic [DATA_W-1:0] rd_word;

  zt_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  zt_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cke        (cke),
    .cs1_n      (cs1_n),
    .cs2        (cs2),
    .cs3_n      (cs3_n),
    .we         (we),
    .burst_cont (burst_cont),
    .seq_mode   (seq_mode),
    .addr       (addr),
    .byte_sel   (byte_sel),
    .cmd_vld    (cmd_vld),
    .cmd_wr     (cmd_wr),
    .cmd_addr   (cmd_addr),
    .cmd_be     (cmd_be)
  );

  // write data phase: data taken at the enabled edge after the address
  assign commit = cke && cmd_vld && cmd_wr;

  zt_sram_array #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_array (
    .clk     (clk),
    .wr_en   (commit),
    .wr_addr (cmd_addr),
    .wr_be   (cmd_be),
    .wr_data (wdata),
    .rd_addr (cmd_addr),
    .rd_data (rd_word)
  );

  assign rvalid = cmd_vld && !cmd_wr && !oe_n;
  assign rdata  = rvalid ? rd_word : '0;

  // R6: the cycle after a loaded write is never driven
  a_r6_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cke && !cs1_n && cs2 && !cs3_n && we && !burst_cont) |=> !rvalid);

  // R7: output enable high means no drive
  a_r7_oe_gates_drive: assert property (@(posedge clk) disable iff (!rst_int_n)
    oe_n |-> (!rvalid && rdata == '0));
endmodule

// File: tb/zt_sram_bench.sv
module zt_sram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANE_W = 9;
  localparam int LANES  = 4;
  localparam int ADDR_W = 6;
  localparam int DATA_W = LANE_W * LANES;

  logic              clk = 1'b0;
  logic              rst_n, cke, cs1_n, cs2, cs3_n, we, burst_cont, seq_mode, oe_n;
  logic [ADDR_W-1:0] addr;
  logic [LANES-1:0]  byte_sel;
  logic [DATA_W-1:0] wdata, rdata;
  logic              rvalid;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zt_sram #(.LANE_W(LANE_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_zt_sram (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .we(we), .burst_cont(burst_cont), .seq_mode(seq_mode), .addr(addr),
    .byte_sel(byte_sel), .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rvalid(rvalid)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic v_exp, input logic [DATA_W-1:0] d_exp);
    n_chk++;
    if (rvalid !== v_exp || rdata !== d_exp) begin
      n_bad++;
      $display("FAIL %s: actual rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               req, rvalid, rdata, v_exp, d_exp);
    end
  endtask

  task automatic cmd(input logic [2:0] cs, input logic w, input logic bc,
                     input logic [ADDR_W-1:0] a, input logic [LANES-1:0] be,
                     input logic [DATA_W-1:0] d);
    cke = 1'b1; {cs1_n, cs2, cs3_n} = cs; we = w; burst_cont = bc;
    addr = a; byte_sel = be; wdata = d;
    tick();
  endtask

  localparam logic [2:0] SEL = 3'b010;
  task automatic op_rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    cmd(SEL, 1'b0, 1'b0, a, '1, d);
  endtask
  task automatic op_wr(input logic [ADDR_W-1:0] a, input logic [LANES-1:0] be,
                       input logic [DATA_W-1:0] d);
    cmd(SEL, 1'b1, 1'b0, a, be, d);
  endtask
  task automatic op_idle(input logic [DATA_W-1:0] d);
    cmd(3'b110, 1'b0, 1'b0, '0, '1, d);
  endtask
  task automatic op_bc(input logic [DATA_W-1:0] d);
    cmd(SEL, 1'b0, 1'b1, '0, '1, d);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cke = 1'b1; cs1_n = 1'b1; cs2 = 1'b0; cs3_n = 1'b1; we = 1'b0;
    burst_cont = 1'b0; seq_mode = 1'b1; oe_n = 1'b0; addr = '0; byte_sel = '1; wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 reset idle", 1'b0, '0);
  endtask

  task automatic t_write_read();
    op_wr(6'h05, '1, '0);
    chk("R6 write data phase not driven", 1'b0, '0);
    op_rd(6'h05, 36'h1_2345_6789);
    chk("R4 read right after write", 1'b1, 36'h1_2345_6789);
    op_rd(6'h05, '0);
    chk("R2 flow-through read", 1'b1, 36'h1_2345_6789);
  endtask

  task automatic t_back_to_back();
    op_wr(6'h0A, '1, '0);
    op_wr(6'h0B, '1, 36'hA_AAAA_0001);
    chk("R4 write-write data phase", 1'b0, '0);
    op_rd(6'h0A, 36'h5_5555_0002);
    chk("R4 read after two writes", 1'b1, 36'hA_AAAA_0001);
    op_rd(6'h0B, '0);
    chk("R4 read-read", 1'b1, 36'h5_5555_0002);
    op_wr(6'h0A, '1, '0);
    op_rd(6'h0A, 36'h0_F0F0_F0F3);
    chk("R4 read-write-read", 1'b1, 36'h0_F0F0_F0F3);
  endtask

  task automatic t_byte_lanes();
    logic [DATA_W-1:0] old_w, new_w, exp_w;
    logic [LANES-1:0] be;
    old_w = 36'hA_AAAA_AAAA; new_w = 36'h1_2345_6789; be = 4'b0101;
    op_wr(6'h08, '1, '0);
    op_wr(6'h08, be, old_w);
    op_rd(6'h08, new_w);
    for (int i = 0; i < LANES; i++)
      exp_w[i*LANE_W +: LANE_W] = be[i] ? new_w[i*LANE_W +: LANE_W] : old_w[i*LANE_W +: LANE_W];
    chk("R3 partial lane write", 1'b1, exp_w);
  endtask

  task automatic t_stall();
    op_rd(6'h05, '0);
    cke = 1'b0; addr = 6'h0A; we = 1'b1;
    repeat (3) tick();
    chk("R5 stalled read holds", 1'b1, 36'h1_2345_6789);
    op_wr(6'h07, '1, '0);
    cke = 1'b0; wdata = 36'hB_0000_0001;
    repeat (2) tick();
    chk("R5 stalled write phase not driven", 1'b0, '0);
    op_rd(6'h07, 36'hB_0000_0002);
    chk("R5 deferred write takes later data", 1'b1, 36'hB_0000_0002);
  endtask

  task automatic t_oe();
    op_rd(6'h05, '0);
    oe_n = 1'b1; #1;
    chk("R7 oe high blocks drive", 1'b0, '0);
    oe_n = 1'b0; #1;
    chk("R7 oe low restores drive", 1'b1, 36'h1_2345_6789);
    op_wr(6'h09, '1, '0);
    chk("R6 write phase with oe low", 1'b0, '0);
    op_idle(36'h3_3333_3333);
  endtask

  task automatic t_deselect();
    cmd(3'b110, 1'b1, 1'b0, 6'h05, '1, '0);
    chk("R8 cs1_n high no drive", 1'b0, '0);
    cmd(3'b000, 1'b1, 1'b0, 6'h05, '1, 36'hD_EAD0_0000);
    chk("R8 cs2 low no drive", 1'b0, '0);
    cmd(3'b011, 1'b0, 1'b0, 6'h05, '1, 36'hD_EAD0_0001);
    chk("R8 cs3_n high no drive", 1'b0, '0);
    op_rd(6'h05, 36'hD_EAD0_0002);
    chk("R8 deselected writes left memory alone", 1'b1, 36'h1_2345_6789);
  endtask

  task automatic t_burst_linear();
    seq_mode = 1'b1;
    op_wr(6'h12, '1, '0);
    op_bc(36'h0_0000_0010);
    op_bc(36'h0_0000_0011);
    op_bc(36'h0_0000_0012);
    op_idle(36'h0_0000_0013);
    op_rd(6'h12, '0); chk("R9 linear word 0 at 0x12", 1'b1, 36'h0_0000_0010);
    op_rd(6'h13, '0); chk("R9 linear word 1 at 0x13", 1'b1, 36'h0_0000_0011);
    op_rd(6'h10, '0); chk("R9 linear wrap word 2 at 0x10", 1'b1, 36'h0_0000_0012);
    op_rd(6'h11, '0); chk("R9 linear word 3 at 0x11", 1'b1, 36'h0_0000_0013);
  endtask

  task automatic t_burst_interleave();
    op_wr(6'h20, '1, '0);
    op_wr(6'h21, '1, 36'h0_0000_0A20);
    op_wr(6'h22, '1, 36'h0_0000_0A21);
    op_wr(6'h23, '1, 36'h0_0000_0A22);
    seq_mode = 1'b0;
    op_rd(6'h21, 36'h0_0000_0A23);
    chk("R10 interleaved start 1", 1'b1, 36'h0_0000_0A21);
    op_bc('0); chk("R10 interleaved step 1 to 0", 1'b1, 36'h0_0000_0A20);
    op_bc('0); chk("R10 interleaved step 2 to 3", 1'b1, 36'h0_0000_0A23);
    op_bc('0); chk("R10 interleaved step 3 to 2", 1'b1, 36'h0_0000_0A22);
    op_idle('0);
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_back_to_back();
    t_byte_lanes();
    t_stall();
    t_oe();
    t_deselect();
    t_burst_linear();
    t_burst_interleave();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog R1..R10 run: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule